// File: doc/BRIEF.md
# Return Address Predictor Stack

This block keeps predicted return targets for the fetch-stage branch predictor. Each cycle it takes at most one decoded control-transfer event, together with the address of the instruction after the transfer. Three kinds of event change the stack. A subroutine call pushes that address. A subroutine return predicts the top entry and pops it. A coroutine transfer predicts the top entry and then overwrites it in place with its own follow-on address, so the stack neither grows nor shrinks.

The coroutine transfer is what sets this stack apart. When two stackful coroutines hand control back and forth, each resumes just after its last transfer. Overwriting the top in place places the resumption address of one coroutine where the next transfer looks for it. The return addresses of the code that called into the coroutines stay untouched below the top. Calls and returns made between transfers cancel out, so they leave the top as it was.

Storage is a circular buffer addressed by a top pointer. A push into a full stack overwrites the oldest entry, and occupancy stops at the depth. A return or coroutine transfer on an empty stack reports no valid prediction. The prediction is combinational from the current top entry. Updates take effect on the next clock edge.

Top module: `ras_predictor`

## Requirements
- R1: After a synchronous active-low reset, occupancy is 0 and no prediction is valid.
- R2: An event code of 1 (call) stores the supplied address as the new top entry and raises occupancy by one. `pred_valid` stays low for a call.
- R3: An event code of 2 (return) on a non-empty stack drives `pred_valid` high with `pred_target` equal to the top entry in the same cycle. On the next edge it removes that entry and lowers occupancy by one.
- R4: An event code of 3 (coroutine transfer) on a non-empty stack predicts the top entry in the same cycle. On the next edge it replaces that entry with the supplied address and leaves occupancy unchanged.
- R5: Any number of coroutine transfers leave every entry below the top unchanged, so later returns still predict them in order.
- R6: A call followed by its matching return, made between coroutine transfers, leaves the top entry that the next transfer predicts unchanged.
- R7: A call into a full stack discards the oldest entry, keeps occupancy at DEPTH, and makes the new address the top.
- R8: A return on an empty stack drives `pred_valid` low and leaves occupancy at 0.
- R9: A coroutine transfer on an empty stack drives `pred_valid` low and then holds its address as the only entry, with occupancy 1.
- R10: An event code of 0 (none) changes neither occupancy nor the top entry, and `pred_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_kind | input | 2 | Event code: 0 none, 1 call, 2 return, 3 coroutine transfer |
| ev_next_pc | input | ADDR_W | Address of the instruction following the transfer |
| pred_valid | output | 1 | Prediction valid for a return or coroutine transfer on a non-empty stack |
| pred_target | output | ADDR_W | Current top entry, which is the predicted target |
| occupancy | output | $clog2(DEPTH+1) | Number of live entries |

## Verification
The bench builds the stack with DEPTH set to 4 and ADDR_W set to 16. With the small depth, a few calls are enough to reach the full stack, and the wraparound that drops the oldest entry (R7) shows up in the directed sequence. It also shows up often in a long random event mix. The pointer passes across the wrap point in both directions many times. Empty-stack returns and empty-stack coroutine transfers happen often in that mix, and each result is compared every cycle against a queue model.

// File: rtl/ras_pkg.sv
// Package: shared event encoding for the return address predictor stack.
// Assumes the decoder presents at most one event per cycle using these codes.
package ras_pkg;
    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_CALL = 2'd1,
        EV_RET  = 2'd2,
        EV_CORO = 2'd3
    } ras_ev_e;
endpackage

// File: rtl/ras_ptr_ctrl.sv
// Module: ras_ptr_ctrl
// Keeps the top-of-stack index and the occupancy count, and decides for each
// event whether an entry is written and which one.
// Assumes: DEPTH >= 1. The pointer wraps modulo DEPTH, so DEPTH need not be a
// power of two. The index is only meaningful while occupancy is non-zero.
module ras_ptr_ctrl #(
    parameter int DEPTH = 8,
    parameter int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter int OCC_W = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  ras_pkg::ras_ev_e   ev_kind,
    output logic [PTR_W-1:0]   tos_idx,
    output logic [OCC_W-1:0]   occ,
    output logic               wr_en,
    output logic [PTR_W-1:0]   wr_idx,
    output logic               pred_ok
);
    import ras_pkg::*;

    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
    localparam logic [OCC_W-1:0] FULL_OCC = OCC_W'(DEPTH);

    logic [PTR_W-1:0] tos_q, tos_d, idx_up, idx_down;
    logic [OCC_W-1:0] occ_q, occ_d;
    logic             has_entry, is_full;

    // Status flags and the neighbouring indices, with wrap at the buffer end.
    always_comb begin
        has_entry = (occ_q != '0);
        is_full   = (occ_q == FULL_OCC);
        idx_up    = (tos_q == LAST_IDX) ? '0 : tos_q + 1'b1;
        idx_down  = (tos_q == '0) ? LAST_IDX : tos_q - 1'b1;
    end

    // Event decode: next pointer, next count and the write strobe.
    always_comb begin
        tos_d   = tos_q;
        occ_d   = occ_q;
        wr_en   = 1'b0;
        wr_idx  = idx_up;
        pred_ok = 1'b0;
        unique case (ev_kind)
            EV_CALL: begin
                tos_d  = idx_up;
                occ_d  = is_full ? occ_q : occ_q + 1'b1;
                wr_en  = 1'b1;
                wr_idx = idx_up;
            end
            EV_RET: begin
                pred_ok = has_entry;
                if (has_entry) begin
                    tos_d = idx_down;
                    occ_d = occ_q - 1'b1;
                end
            end
            EV_CORO: begin
                pred_ok = has_entry;
                wr_en   = 1'b1;
                if (has_entry) begin
                    wr_idx = tos_q;
                end else begin
                    tos_d  = idx_up;
                    occ_d  = OCC_W'(1);
                    wr_idx = idx_up;
                end
            end
            default: begin
            end
        endcase
    end

    // Pointer and count registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tos_q <= LAST_IDX;
            occ_q <= '0;
        end else begin
            tos_q <= tos_d;
            occ_q <= occ_d;
        end
    end

    assign tos_idx = tos_q;
    assign occ     = occ_q;
endmodule

// File: rtl/ras_storage.sv
// Module: ras_storage
// Holds the circular buffer of predicted addresses. It has one write port and
// one combinational read port.
// Assumes: entry contents need no reset, because occupancy gates their use.
module ras_storage #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    parameter int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_data
);
    logic [DEPTH-1:0][ADDR_W-1:0] slot_view;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [ADDR_W-1:0] slot_q;
        // Load this slot when the write port selects it.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == PTR_W'(g))) begin
                slot_q <= wr_data;
            end
        end
        assign slot_view[g] = slot_q;
    end

    // Read mux for the top entry.
    always_comb begin
        rd_data = slot_view[rd_idx];
    end
endmodule

// File: rtl/ras_predictor.sv
// Module: ras_predictor (top)
// Return address predictor stack. Calls push, returns predict and pop, and
// coroutine transfers predict and then overwrite the top entry in place.
// Assumes: one event per cycle. The prediction is combinational and the stack
// update lands on the next clock edge.
module ras_predictor #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    localparam int OCC_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        ev_kind,
    input  logic [ADDR_W-1:0] ev_next_pc,
    output logic              pred_valid,
    output logic [ADDR_W-1:0] pred_target,
    output logic [OCC_W-1:0]  occupancy
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    ras_pkg::ras_ev_e  ev_e;
    logic [PTR_W-1:0]  tos_idx, wr_idx;
    logic              wr_en;

    assign ev_e = ras_pkg::ras_ev_e'(ev_kind);

    ras_ptr_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .OCC_W(OCC_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev_kind (ev_e),
        .tos_idx (tos_idx),
        .occ     (occupancy),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .pred_ok (pred_valid)
    );

    ras_storage #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (ev_next_pc),
        .rd_idx  (tos_idx),
        .rd_data (pred_target)
    );
endmodule

// File: rtl/ras_predictor_chk.sv
// Module: ras_predictor_chk
// Temporal checks on the ports of ras_predictor, attached with bind.
// Assumes: the same parameters as the instance it watches.
module ras_predictor_chk #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    localparam int OCC_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        ev_kind,
    input logic [ADDR_W-1:0] ev_next_pc,
    input logic              pred_valid,
    input logic [ADDR_W-1:0] pred_target,
    input logic [OCC_W-1:0]  occupancy
);
    localparam logic [OCC_W-1:0] FULL_OCC = OCC_W'(DEPTH);

    p_call_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_kind == 2'd1 && occupancy != FULL_OCC)
        |=> (occupancy == $past(occupancy) + 1'b1) && (pred_target == $past(ev_next_pc)));

    p_call_no_pred_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_kind == 2'd1) |-> !pred_valid);

    p_ret_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_kind == 2'd2 && occupancy != '0)
        |-> pred_valid ##1 (occupancy == $past(occupancy) - 1'b1));

    p_coro_inplace_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_kind == 2'd3 && occupancy != '0)
        |=> $stable(occupancy) && (pred_target == $past(ev_next_pc)));

    p_full_saturate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_kind == 2'd1 && occupancy == FULL_OCC)
        |=> (occupancy == FULL_OCC) && (pred_target == $past(ev_next_pc)));

    p_empty_ret_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_kind == 2'd2 && occupancy == '0) |-> !pred_valid ##1 (occupancy == '0));

    p_empty_coro_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_kind == 2'd3 && occupancy == '0)
        |-> !pred_valid ##1 (occupancy == OCC_W'(1)));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_kind == 2'd0) |-> !pred_valid ##1 ($stable(occupancy) && $stable(pred_target)));

    p_occ_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy <= FULL_OCC);
endmodule

bind ras_predictor ras_predictor_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_kind     (ev_kind),
    .ev_next_pc  (ev_next_pc),
    .pred_valid  (pred_valid),
    .pred_target (pred_target),
    .occupancy   (occupancy)
);

// File: tb/tb_ras_predictor.sv
// Bench: drives directed and random event streams and compares the outputs
// against a queue model on every clock.
module tb_ras_predictor;
    localparam int DEPTH  = 4;
    localparam int ADDR_W = 16;
    localparam int OCC_W  = $clog2(DEPTH + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        ev_kind = 2'd0;
    logic [ADDR_W-1:0] ev_next_pc = '0;
    logic              pred_valid;
    logic [ADDR_W-1:0] pred_target;
    logic [OCC_W-1:0]  occupancy;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [ADDR_W-1:0] model[$];

    always #10 clk = ~clk;

    ras_predictor #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .ev_kind(ev_kind), .ev_next_pc(ev_next_pc),
        .pred_valid(pred_valid), .pred_target(pred_target), .occupancy(occupancy)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Present one event after a falling edge and check the prediction. Step
    // the model at the rising edge, then check the state at the next falling edge.
    task automatic step(input string req, input logic [1:0] kind, input logic [ADDR_W-1:0] pc);
        bit exp_v;
        ev_kind    = kind;
        ev_next_pc = pc;
        #1;
        exp_v = (kind == 2'd2 || kind == 2'd3) && model.size() > 0;
        check(req, "pred_valid", int'(pred_valid), int'(exp_v));
        if (exp_v) check(req, "pred_target", int'(pred_target), int'(model[$]));
        @(posedge clk);
        case (kind)
            2'd1: begin
                if (model.size() == DEPTH) void'(model.pop_front());
                model.push_back(pc);
            end
            2'd2: if (model.size() > 0) void'(model.pop_back());
            2'd3: if (model.size() > 0) model[$] = pc; else model.push_back(pc);
            default: ;
        endcase
        @(negedge clk);
        check(req, "occupancy", int'(occupancy), model.size());
        if (model.size() > 0) check(req, "top entry", int'(pred_target), int'(model[$]));
    endtask

    initial begin : watchdog
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1", "reset occupancy", int'(occupancy), 0);
        check("R1", "reset pred_valid", int'(pred_valid), 0);
        // R2: calls push
        step("R2", 2'd1, 16'h0100);
        step("R2", 2'd1, 16'h0200);
        step("R2", 2'd1, 16'h0300);
        // R4: coroutine ping-pong overwrites the top in place
        step("R4", 2'd3, 16'h1000);
        step("R4", 2'd3, 16'h2000);
        step("R4", 2'd3, 16'h1004);
        // R6: call and return between transfers cancel out
        step("R6", 2'd1, 16'h0500);
        step("R6", 2'd2, 16'h0000);
        step("R6", 2'd3, 16'h2004);
        // R5: entries under the top are intact; R3: returns pop
        step("R5", 2'd2, 16'h0000);
        step("R5", 2'd2, 16'h0000);
        step("R3", 2'd2, 16'h0000);
        // R8: returns on empty
        step("R8", 2'd2, 16'h0000);
        step("R8", 2'd2, 16'h0000);
        // R9: coroutine transfer on empty
        step("R9", 2'd3, 16'h3000);
        step("R9", 2'd2, 16'h0000);
        // R7: overflow wraps
        for (int i = 0; i < 6; i++) step("R7", 2'd1, ADDR_W'(16'h4000 + i));
        for (int i = 0; i < 5; i++) step("R7", 2'd2, 16'h0000);
        // R10: idle leaves state
        step("R10", 2'd1, 16'h5555);
        step("R10", 2'd0, 16'h7777);
        step("R10", 2'd0, 16'h8888);
        // random mix covering R2, R3, R4, R7, R8, R9
        for (int i = 0; i < 600; i++) begin
            step("R3", 2'($urandom_range(0, 3)), ADDR_W'($urandom));
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule